// File: doc/BRIEF.md
# Platform Reset Control Port

This block is a one-byte I/O register that software uses to ask for a platform reset. It watches the I/O address bus and responds only to one port address (0xCF9 by default). Any other address is left alone. When software writes a byte there with the trigger bit set, the block raises a system-reset request for one clock cycle. From every write it keeps a single bit, the reset-type flag, and drops the rest of the byte.

A read of the port returns the kept flag in its own bit position, with every other bit zero. A separate output is high whenever the kept value is nonzero. State-saving logic uses that output to decide whether the register needs to be saved. The reset sequencing that acts on the request lives elsewhere in the system.

Top module: `sysrst_ctl_reg`

## Requirements
- R1: After reset, the stored value is 0x00. `sys_reset_req`, `io_rvalid` and `save_needed` are low, and `io_rdata` is 0x00.
- R2: A write to 0xCF9 stores only bit 1 of `io_wdata` (the reset-type flag). The stored value is visible from the next cycle on. Bits 0 and 2..7 are discarded.
- R3: A read of 0xCF9 sets `io_rvalid` high in the next cycle. In that cycle `io_rdata` carries the stored flag in bit 1, and all other bits are 0.
- R4: A write to 0xCF9 with bit 2 of `io_wdata` set drives `sys_reset_req` high in the next cycle, for exactly one cycle per such write. A write with bit 2 clear gives no request.
- R5: A write to any address other than 0xCF9 changes neither the stored value nor `sys_reset_req`.
- R6: A read of any address other than 0xCF9 leaves `io_rvalid` low. Whenever `io_rvalid` is low, `io_rdata` is 0x00.
- R7: `save_needed` is high exactly when the stored value is nonzero. It follows a write from the next cycle on.
- R8: A single write with both bit 1 and bit 2 set both stores the flag and raises the reset request.
- R9: A read and a write to 0xCF9 in the same cycle return the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data, valid while io_rvalid is high |
| io_rvalid | output | 1 | Read response for this port |
| sys_reset_req | output | 1 | One-cycle system-reset request |
| save_needed | output | 1 | Stored value is nonzero |

## Verification
Every result of this block is due exactly one cycle after the access that causes it. This covers the stored flag, `save_needed`, the reset pulse and the read response. The bench drives each access on a falling edge. On the following rising edge it advances a behavioural model. At the next falling edge it compares every output against that model, so each check lands in the cycle after its stimulus. For back-to-back requests and for same-cycle read-and-write, the model takes its values from the access order, not from the design.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
   typedef struct packed {
      logic wr;
      logic rd;
   } io_hit_t;

   function automatic int unsigned addr_bits_needed(input int unsigned value);
      int unsigned n;
      n = 1;
      while ((value >> n) != 0) n++;
      return n;
   endfunction
endpackage

// File: rtl/sysrst_addr_decode.sv
module sysrst_addr_decode #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PORT_ADDR = 'hCF9
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   output sysrst_pkg::io_hit_t hit
);
   localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);

   logic addr_match;
   assign addr_match = (io_addr == MATCH);
   assign hit.wr     = io_wr & addr_match;
   assign hit.rd     = io_rd & addr_match;
endmodule

// File: rtl/sysrst_type_store.sv
module sysrst_type_store #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned TYPE_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              type_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      type_q <= 1'b0;
      else if (wr_hit) type_q <= wdata[TYPE_BIT];
   end

   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> type_q == $past(wdata[TYPE_BIT]));
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(type_q));
endmodule

// File: rtl/sysrst_reset_pulse.sv
module sysrst_reset_pulse #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned TRIG_BIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              req_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= wr_hit & wdata[TRIG_BIT];
   end

   assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> $past(wr_hit && wdata[TRIG_BIT]));
   assert_pulse_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wdata[TRIG_BIT]) |=> req_q);
endmodule

// File: rtl/sysrst_read_port.sv
module sysrst_read_port #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned TYPE_BIT = 1,
   parameter bit          RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_hit,
   input  logic              type_q,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   localparam logic [DATA_W-1:0] TYPE_MASK = DATA_W'(1) << TYPE_BIT;

   logic [DATA_W-1:0] image;
   always_comb begin
      image = '0;
      image[TYPE_BIT] = type_q;
   end

   generate
      if (RD_REG) begin : g_registered
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rvalid <= 1'b0;
               rdata  <= '0;
            end else begin
               rvalid <= rd_hit;
               rdata  <= rd_hit ? image : '0;
            end
         end
         assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_hit |=> rvalid);
      end else begin : g_direct
         assign rvalid = rd_hit;
         assign rdata  = rd_hit ? image : '0;
      end
   endgenerate

   assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> rdata == '0);
   assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~TYPE_MASK) == '0);
endmodule

// File: rtl/sysrst_ctl_reg.sv
module sysrst_ctl_reg #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PORT_ADDR = 'hCF9,
   parameter int unsigned TYPE_BIT  = 1,
   parameter int unsigned TRIG_BIT  = 2,
   parameter bit          RD_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_rvalid,
   output logic              sys_reset_req,
   output logic              save_needed
);
   localparam int unsigned PORT_BITS = sysrst_pkg::addr_bits_needed(PORT_ADDR);

   generate
      if (TYPE_BIT >= DATA_W || TRIG_BIT >= DATA_W) begin : g_bad_bit
         $error("flag bit positions must lie inside the data byte");
      end
      if (TYPE_BIT == TRIG_BIT) begin : g_bad_overlap
         $error("type and trigger bits must differ");
      end
      if (PORT_BITS > ADDR_W) begin : g_bad_addr
         $error("port address does not fit the address width");
      end
   endgenerate

   sysrst_pkg::io_hit_t hit;
   logic                type_q;

   sysrst_addr_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .hit(hit));

   sysrst_type_store #(.DATA_W(DATA_W), .TYPE_BIT(TYPE_BIT)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_hit(hit.wr), .wdata(io_wdata),
      .type_q(type_q));

   sysrst_reset_pulse #(.DATA_W(DATA_W), .TRIG_BIT(TRIG_BIT)) u_pulse (
      .clk(clk), .rst_n(rst_n), .wr_hit(hit.wr), .wdata(io_wdata),
      .req_q(sys_reset_req));

   sysrst_read_port #(.DATA_W(DATA_W), .TYPE_BIT(TYPE_BIT), .RD_REG(RD_REG)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_hit(hit.rd), .type_q(type_q),
      .rdata(io_rdata), .rvalid(io_rvalid));

   assign save_needed = type_q;

   assert_foreign_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr != ADDR_W'(PORT_ADDR)) |=> !sys_reset_req && $stable(save_needed));
   assert_foreign_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_addr == ADDR_W'(PORT_ADDR)) |=> !io_rvalid);
endmodule

// File: tb/sysrst_ctl_reg_tb.sv
module sysrst_ctl_reg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_rvalid;
   logic        sys_reset_req;
   logic        save_needed;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 0;

   logic       m_type = 1'b0;
   logic       e_req = 1'b0, e_rvalid = 1'b0;
   logic [7:0] e_rdata = '0;

   always #10 clk = ~clk;

   sysrst_ctl_reg dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
      .sys_reset_req(sys_reset_req), .save_needed(save_needed));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk(tag, "sys_reset_req", int'(sys_reset_req), int'(e_req));
      chk(tag, "io_rvalid", int'(io_rvalid), int'(e_rvalid));
      chk(tag, "io_rdata", int'(io_rdata), int'(e_rdata));
      chk(tag, "save_needed", int'(save_needed), int'(m_type));
   endtask

   // one access per cycle; model advanced at the edge, outputs compared at the next falling edge
   task automatic cyc(input logic [15:0] a, input logic w, input logic r,
                      input logic [7:0] d, input string tag);
      logic hit;
      io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
      @(posedge clk);
      hit      = (a == 16'hCF9);
      e_rvalid = r && hit;
      e_rdata  = (r && hit) ? {6'b0, m_type, 1'b0} : 8'h00;
      e_req    = w && hit && d[2];
      if (w && hit) m_type = d[1];
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic idle(input string tag);
      cyc(16'h0000, 1'b0, 1'b0, 8'h00, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare_all("R1");
      rst_n = 1'b1;
      idle("R1");
      cyc(16'hCF9, 0, 1, 8'h00, "R1");
      cyc(16'hCF9, 1, 0, 8'h02, "R2");
      cyc(16'hCF9, 0, 1, 8'h00, "R3");
      idle("R7");
      cyc(16'hCF9, 1, 0, 8'hFD, "R4");
      idle("R4");
      cyc(16'hCF9, 0, 1, 8'h00, "R2");
      cyc(16'hCF9, 1, 0, 8'h06, "R8");
      cyc(16'hCF9, 0, 1, 8'h00, "R8");
      cyc(16'hCF8, 1, 0, 8'h04, "R5");
      cyc(16'hCFA, 1, 0, 8'hFF, "R5");
      cyc(16'h1CF9, 1, 0, 8'h04, "R5");
      cyc(16'hCF8, 0, 1, 8'h00, "R6");
      cyc(16'h0CF1, 0, 1, 8'h00, "R6");
      cyc(16'hCF9, 1, 1, 8'h00, "R9");
      cyc(16'hCF9, 0, 1, 8'h00, "R9");
      cyc(16'hCF9, 1, 0, 8'h04, "R4");
      cyc(16'hCF9, 1, 0, 8'h04, "R4");
      idle("R4");
      cyc(16'hCF9, 1, 0, 8'hF9, "R2");
      cyc(16'hCF9, 0, 1, 8'h00, "R3");
      cyc(16'hCF9, 1, 0, 8'h02, "R7");
      idle("R7");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule